// File: doc/BRIEF.md
# Dual-Lane Saturating Fractional Multiplier

This unit multiplies two 64-bit operand vectors lane by lane. Each vector carries two 32-bit lanes (the high lane in bits 63:32, the low lane in bits 31:0). Every lane forms a signed fractional product, which is the exact product doubled. The operands are either one pair of 16-bit halfwords, the full 32-bit words, or both halfword pairs at once. Each lane then optionally clamps its result to the signed or unsigned 32-bit range and raises its own overflow flag when it clamps.

Operations arrive on a valid/ready stream and leave, one cycle later, on a second valid/ready stream. The output stage is a single register. It accepts a new operation in the same cycle that it hands over the previous one. While the consumer holds `out_ready` low with a result pending, the input side stalls: `in_ready` drops and the result and flags stay unchanged. An operation may also ask to copy its 64-bit result into an accumulator register, which is updated on the same clock edge as the result register.

Top module: `fracmul_dual`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operation is taken on a clock edge where `in_valid && in_ready`. Its result appears with `out_valid` high after exactly that edge, and results leave in the order the operations were taken.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`, `out_ovf` and `out_valid` keep their values.
- R3: Mode 0 multiplies the sign-extended low halfwords (bits 15:0) of each lane, and mode 1 multiplies the high halfwords (bits 31:16). The lane value is the product shifted left by one, taken as a 32-bit result.
- R4: Mode 2 multiplies the signed 32-bit lane words. It doubles the exact 64-bit product and takes the arithmetic top half (the doubled product shifted right by 32). The case 0x80000000 × 0x80000000 therefore has the value +2^31 and is detected as out of range.
- R5: Saturation code 1 (signed) replaces a lane value above 0x7FFFFFFF with 0x7FFFFFFF, and a value below −2^31 with 0x80000000. In mode 0, 0x8000 × 0x8000 gives 0x7FFFFFFF.
- R6: Saturation code 2 (unsigned) replaces a negative lane value with 0x00000000 and a value above 0xFFFFFFFF with 0xFFFFFFFF.
- R7: Saturation codes 0 and 3 pass the low 32 bits of the lane value unchanged and never set an overflow flag. For example, 0x8000 × 0x8000 in mode 0 gives 0x80000000.
- R8: Mode 3 forms both halfword products of each lane and saturates each one by the selected code. It packs the upper 16 bits of the high-halfword result into lane bits 31:16 and those of the low-halfword result into bits 15:0. The four halfwords land high lane first: 63:48, 47:32, 31:16, 15:0.
- R9: `out_ovf[1]` belongs to the high lane and `out_ovf[0]` to the low lane. A flag is set exactly when that lane's result was replaced by a saturation constant. In mode 3 this means either of the lane's two halfword results.
- R10: An operation taken with `in_acc_wr` high loads `acc_q` with its 64-bit result on the same edge as `out_data`. Any other edge leaves `acc_q` unchanged.
- R11: During reset (`rst_n` low), `out_valid`, `out_data`, `out_ovf` and `acc_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 64 | First operand vector, high lane in 63:32 |
| in_b | input | 64 | Second operand vector, high lane in 63:32 |
| in_mode | input | 2 | 0 low halfwords, 1 high halfwords, 2 words, 3 both halfwords packed |
| in_sat | input | 2 | 0 none, 1 signed, 2 unsigned, 3 none |
| in_acc_wr | input | 1 | Also load the accumulator with this result |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Packed lane results |
| out_ovf | output | 2 | Per-lane saturation flags |
| acc_q | output | 64 | Accumulator contents |

## Verification
The bound checker watches the stream rules on every cycle. It checks that a taken operation always produces a result, that a stalled result and its flags hold still with `in_ready` low, and that the accumulator moves only on an accepted write and then equals the result. It also checks that unsaturated operations never flag, and that a flagged signed or unsigned lane holds one of its legal clamp constants. The numeric behaviour can only be shown by the bench's scenarios, each compared against an independent wide-integer model. This covers the fractional doubling, the lost-sign-bit word case, the arithmetic rounding toward minus infinity in word mode, the halfword packing order, and which lane owns which flag.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    FM_HALF_LO = 2'd0,
    FM_HALF_HI = 2'd1,
    FM_WORD    = 2'd2,
    FM_QUAD    = 2'd3
  } fm_mode_e;

  typedef enum logic [1:0] {
    SAT_NONE     = 2'd0,
    SAT_SIGNED   = 2'd1,
    SAT_UNSIGNED = 2'd2,
    SAT_RSVD     = 2'd3
  } fm_sat_e;

endpackage

// File: rtl/fmul_sat.sv
module fmul_sat
  import fmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W+1:0] v,
  input  fm_sat_e      kind,
  output logic [W-1:0] y,
  output logic         ovf
);

  localparam logic signed [W+1:0] S_MAX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] S_MIN = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [W+1:0] U_MAX = {2'b00, {W{1'b1}}};

  logic signed [W+1:0] vs;
  assign vs = $signed(v);

  always_comb begin
    y   = v[W-1:0];
    ovf = 1'b0;
    case (kind)
      SAT_SIGNED: begin
        if (vs > S_MAX) begin
          y   = {1'b0, {(W-1){1'b1}}};
          ovf = 1'b1;
        end else if (vs < S_MIN) begin
          y   = {1'b1, {(W-1){1'b0}}};
          ovf = 1'b1;
        end
      end
      SAT_UNSIGNED: begin
        if (vs[W+1]) begin
          y   = '0;
          ovf = 1'b1;
        end else if (vs > U_MAX) begin
          y   = '1;
          ovf = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fmul_lane.sv
module fmul_lane
  import fmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fm_mode_e     mode,
  input  fm_sat_e      sat,
  output logic [W-1:0] y,
  output logic         ovf
);

  localparam int HW = W / 2;
  localparam int DW = 2 * W;

  // halfword products, sign-extended before the multiply
  logic signed [HW-1:0] a_lo, b_lo, a_hi, b_hi;
  logic signed [W-1:0]  p_lo, p_hi;
  logic [W+1:0]         v_lo, v_hi;

  assign a_lo = $signed(a[HW-1:0]);
  assign b_lo = $signed(b[HW-1:0]);
  assign a_hi = $signed(a[W-1:HW]);
  assign b_hi = $signed(b[W-1:HW]);
  assign p_lo = W'(a_lo) * W'(b_lo);
  assign p_hi = W'(a_hi) * W'(b_hi);
  // doubled product, widened by one sign bit
  assign v_lo = {p_lo[W-1], p_lo, 1'b0};
  assign v_hi = {p_hi[W-1], p_hi, 1'b0};

  // word product: exact 2W bits, doubled, top half kept with its sign
  logic signed [W-1:0]  a_w, b_w;
  logic signed [DW-1:0] p_w;
  logic [W+1:0]         v_w;

  assign a_w = $signed(a);
  assign b_w = $signed(b);
  assign p_w = DW'(a_w) * DW'(b_w);
  assign v_w = {p_w[DW-1], p_w[DW-1:W-1]};

  logic [W-1:0] y_lo, y_hi, y_w;
  logic         o_lo, o_hi, o_w;

  fmul_sat #(.W(W)) u_sat_lo (.v(v_lo), .kind(sat), .y(y_lo), .ovf(o_lo));
  fmul_sat #(.W(W)) u_sat_hi (.v(v_hi), .kind(sat), .y(y_hi), .ovf(o_hi));
  fmul_sat #(.W(W)) u_sat_w  (.v(v_w),  .kind(sat), .y(y_w),  .ovf(o_w));

  always_comb begin
    case (mode)
      FM_HALF_LO: begin y = y_lo; ovf = o_lo; end
      FM_HALF_HI: begin y = y_hi; ovf = o_hi; end
      FM_WORD:    begin y = y_w;  ovf = o_w;  end
      default: begin
        y   = {y_hi[W-1:HW], y_lo[W-1:HW]};
        ovf = o_hi | o_lo;
      end
    endcase
  end

endmodule

// File: rtl/fracmul_dual.sv
module fracmul_dual
  import fmul_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*LANE_W-1:0]  in_a,
  input  logic [LANES*LANE_W-1:0]  in_b,
  input  logic [1:0]               in_mode,
  input  logic [1:0]               in_sat,
  input  logic                     in_acc_wr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*LANE_W-1:0]  out_data,
  output logic [LANES-1:0]         out_ovf,
  output logic [LANES*LANE_W-1:0]  acc_q
);

  localparam int VW = LANES * LANE_W;

  fm_mode_e       mode_e;
  fm_sat_e        sat_e;
  logic [VW-1:0]  nxt_data;
  logic [LANES-1:0] nxt_ovf;
  logic           take;

  assign mode_e   = fm_mode_e'(in_mode);
  assign sat_e    = fm_sat_e'(in_sat);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fmul_lane #(.W(LANE_W)) u_lane (
      .a    (in_a[g*LANE_W +: LANE_W]),
      .b    (in_b[g*LANE_W +: LANE_W]),
      .mode (mode_e),
      .sat  (sat_e),
      .y    (nxt_data[g*LANE_W +: LANE_W]),
      .ovf  (nxt_ovf[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= '0;
      acc_q     <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= nxt_data;
        out_ovf   <= nxt_ovf;
        if (in_acc_wr) acc_q <= nxt_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fmul_dual_chk.sv
module fmul_dual_chk #(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [1:0]              in_mode,
  input logic [1:0]              in_sat,
  input logic                    in_acc_wr,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LANE_W-1:0] out_data,
  input logic [LANES-1:0]        out_ovf,
  input logic [LANES*LANE_W-1:0] acc_q
);

  localparam logic [LANE_W-1:0] SPOS = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SNEG = {1'b1, {(LANE_W-1){1'b0}}};

  logic take;
  assign take = in_valid && in_ready;

  p_accept_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_noready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));

  p_ssat_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sat == 2'd1 && in_mode != 2'd3) |=>
      (!out_ovf[0] || out_data[LANE_W-1:0] == SPOS || out_data[LANE_W-1:0] == SNEG));

  p_usat_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sat == 2'd2 && in_mode != 2'd3) |=>
      (!out_ovf[0] || out_data[LANE_W-1:0] == '0 || out_data[LANE_W-1:0] == '1));

  p_no_sat_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_sat == 2'd0 || in_sat == 2'd3)) |=> (out_ovf == '0));

  p_acc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_acc_wr) |=> (acc_q == out_data));

  p_acc_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && in_acc_wr) |=> $stable(acc_q));

endmodule

bind fracmul_dual fmul_dual_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_sat(in_sat), .in_acc_wr(in_acc_wr),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_ovf(out_ovf), .acc_q(acc_q)
);

// File: tb/fracmul_dual_test.sv
module fracmul_dual_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_mode = '0, in_sat = '0;
  logic        in_acc_wr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [1:0]  out_ovf;
  logic [63:0] acc_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracmul_dual uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .in_sat(in_sat),
    .in_acc_wr(in_acc_wr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ovf(out_ovf), .acc_q(acc_q)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit bp_on = 0;
  logic [63:0] m_acc = '0;

  logic [63:0] q_data[$];
  logic [63:0] q_acc[$];
  logic [1:0]  q_ovf[$];
  string       q_tag[$];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- independent model ----------------
  function automatic logic [32:0] sat_fn(longint v, logic [1:0] s);
    if (s == 2'd1) begin
      if (v > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
      if (v < -64'sd2147483648) return {1'b1, 32'h80000000};
    end else if (s == 2'd2) begin
      if (v < 0)                return {1'b1, 32'h00000000};
      if (v > 64'sd4294967295)  return {1'b1, 32'hFFFFFFFF};
    end
    return {1'b0, v[31:0]};
  endfunction

  function automatic longint hprod(logic [15:0] x, logic [15:0] y);
    return longint'($signed(x)) * longint'($signed(y)) * 2;
  endfunction

  function automatic longint wprod(logic [31:0] x, logic [31:0] y);
    logic signed [127:0] xa, ya, p;
    xa = 128'($signed(x));
    ya = 128'($signed(y));
    p  = xa * ya * 2;
    p  = p >>> 32;
    return longint'(p);
  endfunction

  function automatic logic [32:0] lane_fn(logic [31:0] a, logic [31:0] b,
                                          logic [1:0] m, logic [1:0] s);
    logic [32:0] r1, r0;
    case (m)
      2'd0: return sat_fn(hprod(a[15:0], b[15:0]), s);
      2'd1: return sat_fn(hprod(a[31:16], b[31:16]), s);
      2'd2: return sat_fn(wprod(a, b), s);
      default: begin
        r1 = sat_fn(hprod(a[31:16], b[31:16]), s);
        r0 = sat_fn(hprod(a[15:0], b[15:0]), s);
        return {r1[32] | r0[32], r1[31:16], r0[31:16]};
      end
    endcase
  endfunction

  // ---------------- driver ----------------
  task automatic send(logic [63:0] a, logic [63:0] b, logic [1:0] m,
                      logic [1:0] s, logic aw, string tag);
    logic [32:0] hi, lo;
    logic [63:0] d;
    hi = lane_fn(a[63:32], b[63:32], m, s);
    lo = lane_fn(a[31:0], b[31:0], m, s);
    d  = {hi[31:0], lo[31:0]};
    if (aw) m_acc = d;
    q_data.push_back(d);
    q_ovf.push_back({hi[32], lo[32]});
    q_acc.push_back(m_acc);
    q_tag.push_back(tag);
    @(negedge clk);
    in_a = a; in_b = b; in_mode = m; in_sat = s; in_acc_wr = aw; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_acc_wr = 1'b0;
  endtask

  // ---------------- consumer back-pressure ----------------
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
    end
  end

  // ---------------- monitor / scoreboard ----------------
  initial begin
    bit stall_prev = 0;
    logic [63:0] held_d = '0;
    logic [1:0]  held_o = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (stall_prev) begin
          // R2: a stalled result must stay put
          chk(out_valid && out_data == held_d && out_ovf == held_o, "R2",
              "stalled result moved", out_data, held_d);
        end
        if (out_valid && !out_ready)
          chk(!in_ready, "R2", "in_ready while stalled", 64'(in_ready), 64'd0);
        stall_prev = out_valid && !out_ready;
        held_d = out_data;
        held_o = out_ovf;
        if (out_valid && out_ready) begin
          if (q_data.size() == 0) begin
            chk(1'b0, "R1", "unexpected result", out_data, 64'd0);
          end else begin
            logic [63:0] ed, ea;
            logic [1:0]  eo;
            string t;
            ed = q_data.pop_front();
            eo = q_ovf.pop_front();
            ea = q_acc.pop_front();
            t  = q_tag.pop_front();
            chk(out_data == ed, t, "data", out_data, ed);
            chk(out_ovf == eo, t == "R10" ? "R9" : t, "ovf R9", 64'(out_ovf), 64'(eo));
            chk(acc_q == ea, "R10", "acc", acc_q, ea);
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "R1", "watchdog expired", 64'(q_data.size()), 64'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(acc_q == 64'd0, "R11", "acc in reset", acc_q, 64'd0);
    chk(out_ovf == 2'd0 && out_data == 64'd0, "R11", "data in reset", out_data, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "ready when empty", 64'(in_ready), 64'd1);

    // R3: low halfwords 0.5*0.5 and -0.5*0.5
    send({32'h0000_C000, 32'h1234_4000}, {32'h0000_4000, 32'hABCD_4000}, 2'd0, 2'd1, 1'b0, "R3");
    // R3: high halfwords
    send({32'h7FFF_0001, 32'hC000_0000}, {32'h7FFF_0002, 32'hC000_FFFF}, 2'd1, 2'd1, 1'b0, "R3");
    // R5: 0x8000*0x8000 saturates in low lane only
    send({32'h0000_0100, 32'h0000_8000}, {32'h0000_0100, 32'h0000_8000}, 2'd0, 2'd1, 1'b0, "R5");
    // R9: same case in high lane only
    send({32'h0000_8000, 32'h0000_0003}, {32'h0000_8000, 32'h0000_0005}, 2'd0, 2'd1, 1'b0, "R9");
    // R7: no saturation wraps to 0x80000000, code 3 behaves the same
    send({32'h0000_8000, 32'h0000_8000}, {32'h0000_8000, 32'h0000_8000}, 2'd0, 2'd0, 1'b0, "R7");
    send({32'h8000_0000, 32'h0000_8000}, {32'h8000_0000, 32'h0000_8000}, 2'd2, 2'd3, 1'b0, "R7");
    // R4: word mode, 0.5*0.5 and -1*-1 (lost sign bit)
    send({32'h8000_0000, 32'h4000_0000}, {32'h8000_0000, 32'h4000_0000}, 2'd2, 2'd1, 1'b0, "R4");
    // R4: arithmetic top half, -2*2 -> 0xFFFFFFFF; small positive -> 0
    send({32'hFFFF_FFFF, 32'h0000_0003}, {32'h0000_0002, 32'h0000_0007}, 2'd2, 2'd0, 1'b0, "R4");
    // R6: unsigned clamp of negatives, positives pass
    send({32'h0000_C000, 32'h0000_4000}, {32'h0000_4000, 32'h0000_4000}, 2'd0, 2'd2, 1'b0, "R6");
    send({32'hC000_0000, 32'h8000_0000}, {32'h4000_0000, 32'h8000_0000}, 2'd2, 2'd2, 1'b0, "R6");
    // R8: four halfword products packed, one saturating
    send({32'h4000_8000, 32'hC000_2000}, {32'h4000_8000, 32'h4000_2000}, 2'd3, 2'd1, 1'b0, "R8");
    send({32'h1111_2222, 32'h3333_4444}, {32'h7FFF_8001, 32'hF000_0FFF}, 2'd3, 2'd0, 1'b0, "R8");
    // R10: load accumulator, then leave it
    send({32'h2000_0000, 32'h0000_4000}, {32'h2000_0000, 32'h0000_2000}, 2'd2, 2'd1, 1'b1, "R10");
    send({32'h0000_0001, 32'h0000_0001}, {32'h0000_0001, 32'h0000_0001}, 2'd0, 2'd1, 1'b0, "R10");
    send({32'h0000_8000, 32'h0000_7FFF}, {32'h0000_8000, 32'h0000_7FFF}, 2'd0, 2'd1, 1'b1, "R10");

    // R1/R2: back-to-back with random consumer stalls
    bp_on = 1;
    for (int i = 0; i < 40; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 5 == 0) begin ra[15:0] = 16'h8000; rb[15:0] = 16'h8000; end
      send(ra, rb, 2'($urandom()), 2'($urandom()), 1'($urandom()), "R1");
    end
    idle();
    bp_on = 0;
    while (q_data.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "drained", 64'(out_valid), 64'd0);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule